// File: doc/BRIEF.md
# Stereo Running-Sum Moving-Average Filter

This block smooths a stereo stream of signed audio samples by averaging each channel over a sliding window of the most recent `WIN_LEN` samples. A new sample pair arrives whenever the one-cycle `sample_en` strobe is high, roughly 48,000 times per second. On every other clock the filter is frozen.

Each channel scales its incoming sample down by the window length using an arithmetic right shift by log2(`WIN_LEN`). The scaled value enters a shift-register delay line of `WIN_LEN` entries. A single accumulator then adds the new scaled value and subtracts the scaled value that leaves the oldest position. The accumulator drives the output directly, so the output is the sum of the scaled samples now held in the window.

`WIN_LEN` is a power of two of at least 2, and elaboration stops for any other value. Both channels use identical hardware and do not interact. The block has no state machine: its only state is the delay line and the accumulator, and `sample_en` selects between holding and advancing.

Top module: `mavg_stereo`

## Requirements
- R1: While `rst` is high at a rising clock edge, every delay-line entry and both accumulators are cleared, so both outputs read 0 after that edge.
- R2: On a rising edge where `sample_en` is low, both outputs and the delay-line contents keep their values, whatever the inputs carry.
- R3: Each input sample is scaled by an arithmetic right shift of log2(`WIN_LEN`) bits with sign fill, which rounds toward negative infinity. With `WIN_LEN`=16 after reset, a single sample of -1 gives an output of -1, and a single sample of 15 gives 0.
- R4: After each enabled edge, each output equals the 24-bit two's-complement sum of the scaled versions of the last `WIN_LEN` enabled samples of its channel.
- R5: For the first `WIN_LEN` enabled samples after reset, each output is the partial sum of the scaled samples received since reset.
- R6: The left and right channels are independent: the value on one channel's input has no effect on the other channel's output.
- R7: A sample presented with `sample_en` high appears in the output right after that rising edge, and not earlier.
- R8: No overflow occurs at full scale. With `WIN_LEN`=16, a window full of 8388607 gives 8388592, and a window full of -8388608 gives -8388608.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_en | input | 1 | One-cycle strobe that accepts a new sample pair |
| in_left | input | SAMPLE_W | Left input sample, signed |
| in_right | input | SAMPLE_W | Right input sample, signed |
| out_left | output | SAMPLE_W | Left averaged output, signed |
| out_right | output | SAMPLE_W | Right averaged output, signed |

## Verification
A corrupted delay-line entry stays hidden at the ports until it reaches the oldest position. It then shows up as a wrong subtraction, up to `WIN_LEN` enabled samples later, and the error stays in the running sum for good. A wrong accumulator update, by contrast, shows up right after the enabled edge that caused it. For these reasons the bench compares against a shifted-sample model at every enabled edge, over runs much longer than one window. It also checks that the outputs stay stable through idle gaps, so that any state that moves during a gap is caught when it later leaves the window.

// File: rtl/mavg_pkg.sv
package mavg_pkg;
    // Channel index used to build the per-channel lanes.
    typedef enum logic {
        CH_LEFT  = 1'b0,
        CH_RIGHT = 1'b1
    } chan_e;

    localparam int unsigned NUM_CH = 2;
endpackage

// File: rtl/mavg_taps.sv
// Shift-register delay line holding pre-scaled samples; index 0 is newest.
module mavg_taps #(
    parameter int unsigned W = 24,
    parameter int unsigned N = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                shift_en,
    input  logic signed [W-1:0] din,
    output logic signed [W-1:0] oldest
);
    logic signed [W-1:0] taps [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            taps[0] <= '0;
        end else if (shift_en) begin
            taps[0] <= din;
        end
    end

    for (genvar i = 1; i < N; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                taps[i] <= '0;
            end else if (shift_en) begin
                taps[i] <= taps[i-1];
            end
        end
    end

    assign oldest = taps[N-1];

    AST_TAP_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> taps[1] == $past(taps[0])); // R4
    AST_TAP_HOLD: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(taps[N-1]) && $stable(taps[0])); // R2
    AST_TAP_CLEAR: assert property (@(posedge clk)
        rst |=> taps[0] == '0 && taps[N-1] == '0); // R1
endmodule

// File: rtl/mavg_lane.sv
// One channel: scale, delay, running add-and-subtract accumulator.
module mavg_lane #(
    parameter int unsigned W = 24,
    parameter int unsigned N = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sample_en,
    input  logic signed [W-1:0] din,
    output logic signed [W-1:0] dout
);
    localparam int unsigned SHIFT = $clog2(N);

    logic signed [W-1:0] scaled;
    logic signed [W-1:0] leaving;
    logic signed [W-1:0] acc;

    // Arithmetic shift with sign fill: floor division by N.
    assign scaled = din >>> SHIFT;

    mavg_taps #(.W(W), .N(N)) u_taps (
        .clk      (clk),
        .rst      (rst),
        .shift_en (sample_en),
        .din      (scaled),
        .oldest   (leaving)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
        end else if (sample_en) begin
            acc <= acc + scaled - leaving;
        end
    end

    assign dout = acc;

    AST_ACC_HOLD: assert property (@(posedge clk) disable iff (rst)
        !sample_en |=> $stable(dout)); // R2
    AST_ACC_CLEAR: assert property (@(posedge clk)
        rst |=> dout == '0); // R1
    AST_ACC_STEP: assert property (@(posedge clk) disable iff (rst)
        sample_en |=> dout - $past(dout) == $past(scaled) - $past(leaving)); // R4
endmodule

// File: rtl/mavg_stereo.sv
module mavg_stereo
    import mavg_pkg::*;
#(
    parameter int unsigned SAMPLE_W = 24,
    parameter int unsigned WIN_LEN  = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       sample_en,
    input  logic signed [SAMPLE_W-1:0] in_left,
    input  logic signed [SAMPLE_W-1:0] in_right,
    output logic signed [SAMPLE_W-1:0] out_left,
    output logic signed [SAMPLE_W-1:0] out_right
);
    if ((WIN_LEN < 2) || ((WIN_LEN & (WIN_LEN - 1)) != 0)) begin : g_bad_len
        $error("WIN_LEN must be a power of two of at least 2");
    end

    logic signed [SAMPLE_W-1:0] lane_in  [NUM_CH];
    logic signed [SAMPLE_W-1:0] lane_out [NUM_CH];

    assign lane_in[CH_LEFT]  = in_left;
    assign lane_in[CH_RIGHT] = in_right;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
        mavg_lane #(.W(SAMPLE_W), .N(WIN_LEN)) u_lane (
            .clk       (clk),
            .rst       (rst),
            .sample_en (sample_en),
            .din       (lane_in[c]),
            .dout      (lane_out[c])
        );
    end

    assign out_left  = lane_out[CH_LEFT];
    assign out_right = lane_out[CH_RIGHT];
endmodule

// File: tb/mavg_stereo_test.sv
module mavg_stereo_test;
    localparam int N  = 16;
    localparam int W  = 24;
    localparam int SH = $clog2(N);
    localparam int NV = 12;

    // Stimulus vectors: left sample, right sample, idle cycles after it.
    localparam logic signed [W-1:0] VL [NV] = '{
        24'sd1000, -24'sd1000, 24'sd4095, -24'sd17, 24'sd8388607, -24'sd8388608,
        24'sd31, 24'sd0, -24'sd1, 24'sd123456, -24'sd654321, 24'sd16};
    localparam logic signed [W-1:0] VR [NV] = '{
        -24'sd5, 24'sd77, 24'sd0, 24'sd300000, -24'sd300000, 24'sd15,
        -24'sd16, 24'sd8388607, 24'sd2, -24'sd33, 24'sd999, -24'sd8388608};
    localparam int VG [NV] = '{0, 3, 1, 0, 5, 2, 0, 7, 1, 0, 4, 2};

    logic clk = 1'b0;
    logic rst;
    logic en;
    logic signed [W-1:0] inl, inr;
    logic signed [W-1:0] outl, outr;
    logic signed [W-1:0] hl [N];
    logic signed [W-1:0] hr [N];
    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    mavg_stereo #(.SAMPLE_W(W), .WIN_LEN(N)) uut (
        .clk(clk), .rst(rst), .sample_en(en),
        .in_left(inl), .in_right(inr), .out_left(outl), .out_right(outr));

    task automatic check(input string req, input logic signed [W-1:0] act,
                         input logic signed [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic signed [W-1:0] wsum(input logic signed [W-1:0] h [N]);
        logic signed [W-1:0] s = '0;
        for (int i = 0; i < N; i++) s = s + h[i];
        return s;
    endfunction

    task automatic clear_model();
        for (int i = 0; i < N; i++) begin
            hl[i] = '0;
            hr[i] = '0;
        end
    endtask

    // Drive one enabled sample pair and check both outputs after the edge.
    task automatic push(input logic signed [W-1:0] l, input logic signed [W-1:0] r,
                        input string req);
        logic signed [W-1:0] pl, pr;
        @(negedge clk);
        pl = outl;
        pr = outr;
        inl = l;
        inr = r;
        en  = 1'b1;
        #1;
        check("R7 pre-edge left", outl, pl);
        for (int i = N - 1; i > 0; i--) begin
            hl[i] = hl[i-1];
            hr[i] = hr[i-1];
        end
        hl[0] = l >>> SH;
        hr[0] = r >>> SH;
        @(negedge clk);
        en = 1'b0;
        check({req, " left"}, outl, wsum(hl));
        check({req, " right"}, outr, wsum(hr));
    endtask

    // Idle cycles with junk on the inputs: outputs must hold.
    task automatic idle(input int k);
        for (int i = 0; i < k; i++) begin
            logic signed [W-1:0] pl, pr;
            pl = outl;
            pr = outr;
            inl = W'($urandom);
            inr = W'($urandom);
            en  = 1'b0;
            @(negedge clk);
            check("R2 hold left", outl, pl);
            check("R2 hold right", outr, pr);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        en  = 1'b1;
        inl = 24'sd5000;
        inr = -24'sd5000;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        en  = 1'b0;
        clear_model();
        check("R1 reset left", outl, '0);
        check("R1 reset right", outr, '0);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst = 1'b1;
        en  = 1'b0;
        inl = '0;
        inr = '0;
        clear_model();
        do_reset();

        // R3: floor rounding of the per-sample shift
        push(-24'sd1, 24'sd15, "R3 scale");
        check("R3 minus one", outl, -24'sd1);
        check("R3 fifteen", outr, 24'sd0);

        // R5: partial sums during warm-up
        for (int i = 0; i < N - 1; i++) push(24'(i * 160 - 900), 24'(i * 33), "R5 warmup");

        // Table walk with gaps, R4 sliding window
        for (int v = 0; v < NV; v++) begin
            push(VL[v], VR[v], "R4 table");
            idle(VG[v]);
        end

        // Random stream with irregular gaps
        for (int i = 0; i < 300; i++) begin
            push(W'($urandom), W'($urandom), "R4 random");
            idle($urandom_range(0, 3));
        end

        // R6: right channel fed zero while left varies
        for (int i = 0; i < N; i++) push(W'($urandom), '0, "R6 fill");
        check("R6 right isolated", outr, '0);

        // R8: full-scale windows
        for (int i = 0; i < N; i++) push(24'sd8388607, -24'sd8388608, "R8 extreme");
        check("R8 max left", outl, 24'sd8388592);
        check("R8 min right", outr, -24'sd8388608);

        // R1: reset mid-stream, then restart
        do_reset();
        push(24'sd160, -24'sd160, "R1 after reset");

        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule